// File: doc/BRIEF.md
# Color LCD Controller Register Interface

This block is the software-visible register set of a color LCD controller. A simple 32-bit peripheral bus reaches it through word-aligned reads and writes inside a 4 KB window. The block holds four panel timing words, the upper and lower frame base addresses, a control word and an interrupt mask. It also keeps a sticky interrupt status that hardware events set and software clears. A small read-only identification area sits at the top of the window.

From the stored values the block derives the active pixel columns and rows, the pixel-depth code and the display-on state, and drives them to the pixel fetch and video timing logic. After every accepted register write it raises a single-cycle `invalidate` strobe, so that downstream logic knows to refetch the frame.

The `VARIANT` parameter selects one of three layouts. `VAR_BASE` keeps the mask word below the control word. `VAR_BOARD` and `VAR_EXT` exchange those two addresses. `VAR_EXT` also reports a different identification sequence.

Top module: `lcdc_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, every stored register, the interrupt status, `active_cols`, `active_rows`, `pix_depth`, `disp_on` and `invalidate` are zero, and reads of timing and control words return zero.
- R2: A write to word index 0 (byte 0x000) sets `active_cols` to (wdata[7:2] + 1) * 16, which equals ((wdata & 0xFC) + 4) * 4. `active_cols` changes at no other time.
- R3: A write to word index 1 (byte 0x004) sets `active_rows` to wdata[9:0] + 1. `active_rows` changes at no other time.
- R4: `disp_on` is high only when control bit 0 (enable) and control bit 11 (power) are both 1. `pix_depth` equals control bits [3:1]. Bits 8 (blue/red swap), 9 (big-endian bytes) and 10 (big-endian pixels) are stored and read back.
- R5: The timing words (indices 0 to 3), the upper base (index 4), the lower base (index 5) and the control word read back as written, at full 32 bits. The mask reads back in its low `NIRQ` bits with zeros above. Indices 11 and 12 return the upper and lower base. Read data appears on `bus_rdata` one clock after the read is accepted and holds until the next read.
- R6: With `VAR_BASE` the mask is at index 6 (byte 0x018) and control is at index 7 (byte 0x01C). With the other two variants these addresses are exchanged, for both reads and writes.
- R7: A high bit of `irq_raise` in a cycle sets that bit of the raw status, which reads at index 8 (byte 0x020). Writing index 10 (byte 0x028) clears each status bit that is 1 in wdata. When a bit is raised and cleared in the same cycle, it ends up set.
- R8: Index 9 (byte 0x024) reads as raw status AND mask.
- R9: Byte offsets 0xFE0 to 0xFFC return one identification byte in rdata[7:0], with zeros above, chosen by (offset - 0xFE0) >> 2. The sequence is 10 11 04 00 0D F0 05 B1 for `VAR_BASE` and `VAR_BOARD`, and 11 11 24 00 0D F0 05 B1 for `VAR_EXT`.
- R10: Reads of index 10, of indices 13 to 1015 and of non-word-aligned addresses return zero. Writes to read-only indices, to unmapped indices or to non-word-aligned addresses change no state and do not pulse `invalidate`.
- R11: `invalidate` is high for exactly the one cycle after each accepted write to indices 0 to 7 or 10, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W (12) | Byte address inside the 4 KB window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_raise | input | NIRQ (5) | Per-bit interrupt event set strobes |
| active_cols | output | GEO_W (11) | Decoded active pixel columns |
| active_rows | output | GEO_W (11) | Decoded active pixel rows |
| pix_depth | output | 3 | Pixel-depth code, control bits [3:1] |
| disp_on | output | 1 | Enable and power both set |
| invalidate | output | 1 | One-cycle strobe after a register write |

## Verification
Every result of this block is due exactly one rising edge after the edge that accepts the stimulus. This holds for read data, for the decoded columns, rows, depth and display-on state, for status changes caused by `irq_raise` or the clear word, and for the `invalidate` strobe. The bench drives bus and event inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, where the registered value has settled and has not yet been overwritten. For the `invalidate` strobe, the bench also samples one falling edge later to confirm that it has dropped.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int GEO_W  = 11;

    typedef enum logic [1:0] {
        VAR_BASE  = 2'd0,
        VAR_BOARD = 2'd1,
        VAR_EXT   = 2'd2
    } lcdc_variant_e;

    localparam logic [IDX_W-1:0] IX_TIM0  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_TIM1  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_TIM2  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_TIM3  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_UBASE = IDX_W'(4);
    localparam logic [IDX_W-1:0] IX_LBASE = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_SLOT6 = IDX_W'(6);
    localparam logic [IDX_W-1:0] IX_SLOT7 = IDX_W'(7);
    localparam logic [IDX_W-1:0] IX_RAW   = IDX_W'(8);
    localparam logic [IDX_W-1:0] IX_MSKD  = IDX_W'(9);
    localparam logic [IDX_W-1:0] IX_CLR   = IDX_W'(10);
    localparam logic [IDX_W-1:0] IX_UCUR  = IDX_W'(11);
    localparam logic [IDX_W-1:0] IX_LCUR  = IDX_W'(12);
    localparam logic [IDX_W-1:0] IX_HOLE  = IDX_W'(13);
    // identification area: last eight words of the window
    localparam logic [IDX_W-1:0] IX_ID0   = IDX_W'((1 << IDX_W) - 8);

endpackage

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic [5:0]       hfield_i,
    input  logic [9:0]       vfield_i,
    output logic [GEO_W-1:0] cols_o,
    output logic [GEO_W-1:0] rows_o
);
    logic [GEO_W-1:0] hunits;

    always_comb begin
        // columns come in groups of 16 pixels, field value n means n+1 groups
        hunits = {{(GEO_W-6){1'b0}}, hfield_i} + GEO_W'(1);
        cols_o = hunits << 4;
        rows_o = {{(GEO_W-10){1'b0}}, vfield_i} + GEO_W'(1);
    end

endmodule

// File: rtl/lcdc_idrom.sv
module lcdc_idrom
    import lcdc_pkg::*;
#(
    parameter lcdc_variant_e VARIANT = VAR_BASE
) (
    input  logic [2:0] sel_i,
    output logic [7:0] byte_o
);
    localparam logic [7:0] ID_B0 = (VARIANT == VAR_EXT) ? 8'h11 : 8'h10;
    localparam logic [7:0] ID_B2 = (VARIANT == VAR_EXT) ? 8'h24 : 8'h04;

    always_comb begin
        case (sel_i)
            3'd0:    byte_o = ID_B0;
            3'd1:    byte_o = 8'h11;
            3'd2:    byte_o = ID_B2;
            3'd3:    byte_o = 8'h00;
            3'd4:    byte_o = 8'h0D;
            3'd5:    byte_o = 8'hF0;
            3'd6:    byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int NIRQ = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] raise_i,
    input  logic            clr_en_i,
    input  logic [NIRQ-1:0] clr_mask_i,
    output logic [NIRQ-1:0] status_o
);
    logic [NIRQ-1:0] status_d, status_q;
    logic [NIRQ-1:0] drop;

    always_comb begin
        drop     = clr_en_i ? clr_mask_i : '0;
        // a raise in the same cycle as a clear wins
        status_d = (status_q & ~drop) | raise_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

    AST_RAISE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_i != '0) |=> ((status_q & $past(raise_i)) == $past(raise_i))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_q & $past(clr_mask_i & ~raise_i)) == '0)); // R7
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en_i && raise_i == '0) |=> $stable(status_q)); // R7

endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter lcdc_variant_e VARIANT = VAR_BASE,
    parameter int            NIRQ    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NIRQ-1:0]   irq_raise,
    output logic [GEO_W-1:0]  active_cols,
    output logic [GEO_W-1:0]  active_rows,
    output logic [2:0]        pix_depth,
    output logic              disp_on,
    output logic              invalidate
);
    localparam logic [IDX_W-1:0] CTRL_IX = (VARIANT == VAR_BASE) ? IX_SLOT7 : IX_SLOT6;
    localparam logic [IDX_W-1:0] MASK_IX = (VARIANT == VAR_BASE) ? IX_SLOT6 : IX_SLOT7;
    localparam int EN_BIT  = 0;
    localparam int PWR_BIT = 11;

    typedef struct packed {
        logic [3:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]      ubase;
        logic [DATA_W-1:0]      lbase;
        logic [DATA_W-1:0]      ctrl;
        logic [NIRQ-1:0]        mask;
        logic [GEO_W-1:0]       cols;
        logic [GEO_W-1:0]       rows;
        logic [DATA_W-1:0]      rdata;
        logic                   inval;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_ok;
    logic             wr_map;
    logic             clr_en;
    logic [GEO_W-1:0] geo_cols, geo_rows;
    logic [7:0]       id_byte;
    logic [NIRQ-1:0]  status;
    logic [DATA_W-1:0] rd_val;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;
    assign clr_en  = wr_ok && (idx == IX_CLR);

    lcdc_geom u_geom (
        .hfield_i (bus_wdata[7:2]),
        .vfield_i (bus_wdata[9:0]),
        .cols_o   (geo_cols),
        .rows_o   (geo_rows)
    );

    lcdc_idrom #(.VARIANT(VARIANT)) u_idrom (
        .sel_i  (idx[2:0]),
        .byte_o (id_byte)
    );

    lcdc_irq #(.NIRQ(NIRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (irq_raise),
        .clr_en_i   (clr_en),
        .clr_mask_i (bus_wdata[NIRQ-1:0]),
        .status_o   (status)
    );

    // read decode
    always_comb begin
        rd_val = '0;
        if (aligned) begin
            if (idx >= IX_ID0) begin
                rd_val = DATA_W'(id_byte);
            end else if (idx == CTRL_IX) begin
                rd_val = r_q.ctrl;
            end else if (idx == MASK_IX) begin
                rd_val = DATA_W'(r_q.mask);
            end else begin
                case (idx)
                    IX_TIM0, IX_TIM1,
                    IX_TIM2, IX_TIM3: rd_val = r_q.tim[idx[1:0]];
                    IX_UBASE:         rd_val = r_q.ubase;
                    IX_LBASE:         rd_val = r_q.lbase;
                    IX_RAW:           rd_val = DATA_W'(status);
                    IX_MSKD:          rd_val = DATA_W'(status & r_q.mask);
                    IX_UCUR:          rd_val = r_q.ubase;
                    IX_LCUR:          rd_val = r_q.lbase;
                    default:          rd_val = '0;
                endcase
            end
        end
    end

    // next state
    always_comb begin
        r_d       = r_q;
        r_d.inval = 1'b0;
        wr_map    = 1'b0;
        if (wr_ok) begin
            if (idx == CTRL_IX) begin
                r_d.ctrl = bus_wdata;
                wr_map   = 1'b1;
            end else if (idx == MASK_IX) begin
                r_d.mask = bus_wdata[NIRQ-1:0];
                wr_map   = 1'b1;
            end else begin
                case (idx)
                    IX_TIM0: begin
                        r_d.tim[0] = bus_wdata;
                        r_d.cols   = geo_cols;
                        wr_map     = 1'b1;
                    end
                    IX_TIM1: begin
                        r_d.tim[1] = bus_wdata;
                        r_d.rows   = geo_rows;
                        wr_map     = 1'b1;
                    end
                    IX_TIM2, IX_TIM3: begin
                        r_d.tim[idx[1:0]] = bus_wdata;
                        wr_map            = 1'b1;
                    end
                    IX_UBASE: begin
                        r_d.ubase = bus_wdata;
                        wr_map    = 1'b1;
                    end
                    IX_LBASE: begin
                        r_d.lbase = bus_wdata;
                        wr_map    = 1'b1;
                    end
                    IX_CLR: begin
                        wr_map = 1'b1;
                    end
                    default: wr_map = 1'b0;
                endcase
            end
        end
        r_d.inval = wr_map;
        r_d.rdata = bus_rd ? rd_val : r_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata   = r_q.rdata;
    assign active_cols = r_q.cols;
    assign active_rows = r_q.rows;
    assign pix_depth   = r_q.ctrl[3:1];
    assign disp_on     = r_q.ctrl[EN_BIT] & r_q.ctrl[PWR_BIT];
    assign invalidate  = r_q.inval;

    AST_NO_INVAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !invalidate); // R11
    AST_INVAL_ON_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(12'h008)) |=> invalidate); // R11
    AST_COLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(12'h000)) |=> $stable(active_cols)); // R2
    AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(12'h004)) |=> $stable(active_rows)); // R3
    AST_ON_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_on) |-> $past(bus_wr)); // R4
    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && idx >= IX_HOLE && idx < IX_ID0) |=> (bus_rdata == '0)); // R10
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R5

endmodule

// File: tb/tb_lcdc_regfile.sv
module tb_lcdc_regfile;
    import lcdc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [4:0]  irq_raise = '0;

    logic [31:0] rdata_b, rdata_x;
    logic [10:0] cols_b, rows_b, cols_x, rows_x;
    logic [2:0]  depth_b, depth_x;
    logic        on_b, on_x, inv_b, inv_x;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    lcdc_regfile #(.VARIANT(VAR_BASE), .NIRQ(5)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .irq_raise(irq_raise), .active_cols(cols_b), .active_rows(rows_b),
        .pix_depth(depth_b), .disp_on(on_b), .invalidate(inv_b)
    );

    lcdc_regfile #(.VARIANT(VAR_EXT), .NIRQ(5)) dut_x (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_x),
        .irq_raise(irq_raise), .active_cols(cols_x), .active_rows(rows_x),
        .pix_depth(depth_x), .disp_on(on_x), .invalidate(inv_x)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 timing0/cols, 1 timing1/rows, 2 control/{on,depth}
        logic [31:0] wd;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_0000, 12'd16},
        '{2'd0, 32'h0000_00FC, 12'd1024},
        '{2'd0, 32'hFFFF_FF03, 12'd16},
        '{2'd0, 32'h0000_0027, 12'd160},
        '{2'd0, 32'h3F3F_3F4C, 12'd320},
        '{2'd1, 32'h0000_0000, 12'd1},
        '{2'd1, 32'h0000_03FF, 12'd1024},
        '{2'd1, 32'hFFFF_FC00, 12'd1},
        '{2'd1, 32'h0000_00EF, 12'd240},
        '{2'd2, 32'h0000_0801, 12'h008},
        '{2'd2, 32'h0000_0001, 12'h000},
        '{2'd2, 32'h0000_0800, 12'h000},
        '{2'd2, 32'h0000_080B, 12'h00D},
        '{2'd2, 32'h0000_070E, 12'h007}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] vb, output logic [31:0] vx);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        vb = rdata_b;
        vx = rdata_x;
    endtask

    function automatic logic [7:0] id_exp(input int i, input bit ext);
        case (i)
            0: return ext ? 8'h11 : 8'h10;
            1: return 8'h11;
            2: return ext ? 8'h24 : 8'h04;
            3: return 8'h00;
            4: return 8'h0D;
            5: return 8'hF0;
            6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] vb, vx;
        logic [10:0] cols_keep, rows_keep;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 cols in reset", 32'(cols_b), 32'd0);
        check("R1 on/depth/inval in reset", {27'd0, on_b, depth_b, inv_b}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rows after reset", 32'(rows_b), 32'd0);
        bus_read(12'h000, vb, vx);
        check("R1 timing0 reads zero", vb, 32'd0);
        bus_read(12'h01C, vb, vx);
        check("R1 control reads zero", vb, 32'd0);
        bus_read(12'h020, vb, vx);
        check("R1 status reads zero", vb, 32'd0);

        // R2 R3 R4 table walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                2'd0: begin
                    bus_write(12'h000, VECS[i].wd);
                    check("R2 columns", 32'(cols_b), 32'(VECS[i].exp));
                end
                2'd1: begin
                    bus_write(12'h004, VECS[i].wd);
                    check("R3 rows", 32'(rows_b), 32'(VECS[i].exp));
                end
                default: begin
                    bus_write(12'h01C, VECS[i].wd);
                    check("R4 on/depth", {28'd0, on_b, depth_b}, 32'(VECS[i].exp));
                end
            endcase
        end
        check("R2 cols kept by rows write", 32'(cols_b), 32'd320);
        bus_read(12'h01C, vb, vx);
        check("R4 control bits 8-10 stored", vb, 32'h0000_070E);

        // R11 invalidate strobe
        bus_write(12'h008, 32'hA5A5_0001);
        check("R11 invalidate after write", 32'(inv_b), 32'd1);
        @(negedge clk);
        check("R11 invalidate one cycle", 32'(inv_b), 32'd0);

        // R5 readback
        bus_write(12'h00C, 32'h1234_5678);
        bus_write(12'h010, 32'h8000_0000);
        bus_write(12'h014, 32'h8004_B000);
        bus_read(12'h008, vb, vx);
        check("R5 timing2", vb, 32'hA5A5_0001);
        bus_read(12'h00C, vb, vx);
        check("R5 timing3", vb, 32'h1234_5678);
        bus_read(12'h000, vb, vx);
        check("R5 timing0", vb, 32'h3F3F_3F4C);
        bus_read(12'h010, vb, vx);
        check("R5 upper base", vb, 32'h8000_0000);
        bus_read(12'h014, vb, vx);
        check("R5 lower base", vb, 32'h8004_B000);
        bus_read(12'h02C, vb, vx);
        check("R5 upper current", vb, 32'h8000_0000);
        bus_read(12'h030, vb, vx);
        check("R5 lower current", vb, 32'h8004_B000);
        repeat (2) @(negedge clk);
        check("R5 rdata holds", rdata_b, 32'h8004_B000);

        // R6 swap between variants
        bus_write(12'h018, 32'h0000_0801);
        bus_write(12'h01C, 32'h0000_001F);
        check("R6 base control at 0x1C", {28'd0, on_b, depth_b}, 32'h7);
        check("R6 ext control at 0x18", {28'd0, on_x, depth_x}, 32'h8);
        bus_read(12'h018, vb, vx);
        check("R6 base mask at 0x18", vb, 32'h0000_0001);
        check("R6 ext control read 0x18", vx, 32'h0000_0801);
        bus_read(12'h01C, vb, vx);
        check("R6 base control read 0x1C", vb, 32'h0000_001F);
        check("R6 ext mask read 0x1C", vx, 32'h0000_001F);

        // R7 R8 status
        @(negedge clk);
        irq_raise = 5'b10110;
        @(negedge clk);
        irq_raise = 5'b00000;
        bus_read(12'h020, vb, vx);
        check("R7 raw status set", vb, 32'h16);
        bus_read(12'h024, vb, vx);
        check("R8 masked base", vb, 32'h0);
        check("R8 masked ext", vx, 32'h16);
        bus_write(12'h028, 32'h0000_0004);
        check("R11 invalidate on clear write", 32'(inv_b), 32'd1);
        bus_read(12'h020, vb, vx);
        check("R7 clear bit 2", vb, 32'h12);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h028; bus_wdata = 32'h12; irq_raise = 5'b00010;
        @(negedge clk);
        bus_wr = 1'b0; irq_raise = 5'b00000;
        bus_read(12'h020, vb, vx);
        check("R7 raise beats clear", vb, 32'h02);
        bus_read(12'h024, vb, vx);
        check("R8 masked after clear", vx, 32'h02);

        // R9 identification
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(4 * i), vb, vx);
            check("R9 id base", vb, 32'(id_exp(i, 1'b0)));
            check("R9 id ext", vx, 32'(id_exp(i, 1'b1)));
        end

        // R10 unmapped and read-only
        bus_read(12'h028, vb, vx);
        check("R10 clear word reads zero", vb, 32'h0);
        bus_read(12'h034, vb, vx);
        check("R10 hole reads zero", vb, 32'h0);
        bus_read(12'h200, vb, vx);
        check("R10 0x200 reads zero", vb, 32'h0);
        bus_read(12'h011, vb, vx);
        check("R10 misaligned read zero", vb, 32'h0);
        cols_keep = cols_b;
        rows_keep = rows_b;
        bus_write(12'h200, 32'hFFFF_FFFF);
        check("R10 unmapped write no invalidate", 32'(inv_b), 32'd0);
        bus_write(12'h001, 32'h0000_0000);
        check("R10 misaligned write no invalidate", 32'(inv_b), 32'd0);
        check("R10 cols unchanged", 32'(cols_b), 32'(cols_keep));
        check("R10 rows unchanged", 32'(rows_b), 32'(rows_keep));
        bus_write(12'h020, 32'h0000_00FF);
        check("R10 status write no invalidate", 32'(inv_b), 32'd0);
        bus_read(12'h020, vb, vx);
        check("R10 status kept", vb, 32'h02);
        bus_write(12'hFE0, 32'h0000_0000);
        bus_read(12'hFE0, vb, vx);
        check("R10 id kept", vb, 32'h10);
        bus_write(12'h02C, 32'h0000_0000);
        bus_read(12'h010, vb, vx);
        check("R10 base kept after current write", vb, 32'h8000_0000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule